// File: doc/BRIEF.md
# Serial EEPROM Write-Protect Register Unit

This unit is the protection logic that sits between the serial bus decoder of an 8K x 8 serial EEPROM and its memory array. It keeps an 8-bit protect register that appears at the highest array address. A random (addressed) read or write of that address reaches the register. A sequential transfer that runs into the same address reaches the array cell instead. Every decoded access is presented on one port together with a flag that says whether it is random or sequential.

The register can only be changed through a fixed unlock order. First the write-latch bit is set. Then the protection-arm bit is set. A final write then commits the new block-protect field and the pin-enable bit and disarms the register. The unit also decides, in the same cycle as each array write request, whether that write is allowed. It bases this on the write-latch bit, the external write-protect pin and the block-protect range. The register value is visible on a read bus at all times.

Top module: `wpr_unit`

## Requirements
- R1: After reset the register reads 0x00 and no array write is permitted.
- R2: `reg_sel` is 1 only for a random access (`acc_seq`=0) to address 0x1FFF. `reg_rd_en` is `acc_rd` and `reg_sel` together. `arr_rd_en` is `acc_rd` with `reg_sel` low.
- R3: The register reads as {WPEN, 0, 0, BP[1:0], RWEL, WEL, 0}, with WPEN at bit 7, BP at bits 4:3, RWEL at bit 2 and WEL at bit 1. Bits 6, 5 and 0 read 0 whatever was written.
- R4: A register write whose bits 2:1 are 01 (for example 0x02) sets WEL when RWEL is clear. It leaves BP and WPEN unchanged, even when the written bits 7, 4 and 3 differ from them.
- R5: A register write whose bits 2:1 are 11 (for example 0x06) sets RWEL when WEL is already 1. When WEL is 0 it has no effect.
- R6: With RWEL set, a register write whose bits 2:1 are 01 loads WPEN from bit 7 and BP from bits 4:3, clears RWEL and keeps WEL at 1.
- R7: A register write whose bit 1 is 0 and bit 2 is 0 clears WEL and RWEL. A write with bits 2:1 equal to 10 is ignored.
- R8: When WPEN is 1 and `wp_pin` is 1, register writes have no effect. When WPEN is 0, `wp_pin` does not block register writes.
- R9: `arr_wr_ok` is 1 exactly when `acc_wr` is 1, `reg_sel` is 0, WEL is 1, `wp_pin` is 0 and the address is outside the protected range. The protected range is none for BP=00, 0x1800 and up for BP=01, 0x1000 and up for BP=10, and the whole array for BP=11.
- R10: A sequential write to 0x1FFF is treated as an array write and leaves the register unchanged.
- R11: Register updates take effect on the clock edge that samples the write strobe. `arr_wr_ok`, `reg_sel` and the read enables follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 13 | Decoded access address |
| acc_wdata | input | 8 | Write data of the access |
| acc_wr | input | 1 | Write strobe, one cycle per byte |
| acc_rd | input | 1 | Read strobe, one cycle per byte |
| acc_seq | input | 1 | 1 when the access continues a sequential transfer |
| wp_pin | input | 1 | External write-protect pin, high blocks writes |
| reg_sel | output | 1 | Access is routed to the protect register |
| reg_rd_en | output | 1 | Read of the protect register |
| arr_rd_en | output | 1 | Read routed to the array |
| arr_wr_ok | output | 1 | Array write permitted this cycle |
| reg_rdata | output | 8 | Protect register read value |

## Verification
The routing outputs and `arr_wr_ok` are combinational, so they are due in the same cycle as the access. The bench compares them a little after the falling edge on which the inputs were driven. A register write shows on `reg_rdata` one rising edge later. The bench therefore advances its own model only after that edge and compares the register on the next falling edge. Each write is followed by a check of the register in the next cycle. Unlock, commit, lock and range cases are each confirmed on the cycle that follows them.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  localparam int unsigned BIT_WPEN  = 7;
  localparam int unsigned BIT_BP_HI = 4;
  localparam int unsigned BIT_BP_LO = 3;
  localparam int unsigned BIT_RWEL  = 2;
  localparam int unsigned BIT_WEL   = 1;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
    logic       rwel;
    logic       wel;
  } wpr_state_t;

  // command decoded from written bits {RWEL, WEL}
  typedef enum logic [1:0] {
    CMD_CLEAR = 2'b00,
    CMD_LATCH = 2'b01,
    CMD_BAD   = 2'b10,
    CMD_ARM   = 2'b11
  } wpr_cmd_e;

  function automatic logic [7:0] pack_reg(input wpr_state_t s);
    logic [7:0] v;
    v = 8'h00;
    v[BIT_WPEN]            = s.wpen;
    v[BIT_BP_HI:BIT_BP_LO] = s.bp;
    v[BIT_RWEL]            = s.rwel;
    v[BIT_WEL]             = s.wel;
    return v;
  endfunction

  // lowest protected address for a block-protect code
  function automatic logic [31:0] prot_floor(input logic [31:0] depth,
                                             input logic [1:0]  bp);
    logic [31:0] lim;
    case (bp)
      2'b00:   lim = depth;
      2'b01:   lim = depth - (depth >> 2);
      2'b10:   lim = depth >> 1;
      default: lim = 32'd0;
    endcase
    return lim;
  endfunction

  function automatic logic in_block(input logic [31:0] addr,
                                    input logic [31:0] depth,
                                    input logic [1:0]  bp);
    return addr >= prot_floor(depth, bp);
  endfunction

endpackage

// File: rtl/wpr_route.sv
module wpr_route #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              seq,
  input  logic              wr,
  input  logic              rd,
  output logic              reg_sel,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              arr_wr_req,
  output logic              arr_rd
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic top_hit;

  always_comb begin
    top_hit    = (addr == TOP_ADDR);
    reg_sel    = top_hit && !seq;
    reg_wr     = wr && reg_sel;
    reg_rd     = rd && reg_sel;
    arr_wr_req = wr && !reg_sel;
    arr_rd     = rd && !reg_sel;
  end
endmodule

// File: rtl/wpr_lock.sv
module wpr_lock
  import wpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp_pin,
  output wpr_state_t        st,
  output logic              fire,
  output logic              latch_ev,
  output logic              arm_ev,
  output logic              commit_ev,
  output logic              clear_ev
);
  wpr_cmd_e cmd;

  always_comb begin
    cmd       = wpr_cmd_e'(wdata[BIT_RWEL:BIT_WEL]);
    fire      = reg_wr && !(st.wpen && wp_pin);
    latch_ev  = fire && (cmd == CMD_LATCH) && !st.rwel;
    commit_ev = fire && (cmd == CMD_LATCH) && st.rwel;
    arm_ev    = fire && (cmd == CMD_ARM) && st.wel;
    clear_ev  = fire && (cmd == CMD_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      if (latch_ev) st.wel <= 1'b1;
      if (arm_ev)   st.rwel <= 1'b1;
      if (commit_ev) begin
        st.wpen <= wdata[BIT_WPEN];
        st.bp   <= wdata[BIT_BP_HI:BIT_BP_LO];
        st.rwel <= 1'b0;
      end
      if (clear_ev) begin
        st.wel  <= 1'b0;
        st.rwel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpr_gate.sv
module wpr_gate
  import wpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              arr_wr_req,
  input  wpr_state_t        st,
  input  logic              wp_pin,
  output logic              blocked,
  output logic              arr_wr_ok
);
  localparam logic [31:0] DEPTH = 32'd1 << ADDR_W;

  always_comb begin
    blocked   = in_block(32'(addr), DEPTH, st.bp);
    arr_wr_ok = arr_wr_req && st.wel && !wp_pin && !blocked;
  end
endmodule

// File: rtl/wpr_unit.sv
module wpr_unit
  import wpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic              acc_seq,
  input  logic              wp_pin,
  output logic              reg_sel,
  output logic              reg_rd_en,
  output logic              arr_rd_en,
  output logic              arr_wr_ok,
  output logic [DATA_W-1:0] reg_rdata
);
  wpr_state_t st;
  logic reg_wr, arr_wr_req, blocked;
  logic fire, latch_ev, arm_ev, commit_ev, clear_ev;

  wpr_route #(.ADDR_W(ADDR_W)) u_route (
    .addr(acc_addr), .seq(acc_seq), .wr(acc_wr), .rd(acc_rd),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd_en),
    .arr_wr_req(arr_wr_req), .arr_rd(arr_rd_en)
  );

  wpr_lock #(.DATA_W(DATA_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wdata(acc_wdata),
    .wp_pin(wp_pin), .st(st), .fire(fire), .latch_ev(latch_ev),
    .arm_ev(arm_ev), .commit_ev(commit_ev), .clear_ev(clear_ev)
  );

  wpr_gate #(.ADDR_W(ADDR_W)) u_gate (
    .addr(acc_addr), .arr_wr_req(arr_wr_req), .st(st), .wp_pin(wp_pin),
    .blocked(blocked), .arr_wr_ok(arr_wr_ok)
  );

  always_comb begin
    reg_rdata = DATA_W'(pack_reg(st));
  end
endmodule

// File: rtl/wpr_unit_chk.sv
module wpr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_wr,
  input logic       acc_seq,
  input logic       wp_pin,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic       arr_wr_ok,
  input logic       blocked,
  input logic [7:0] reg_rdata,
  input logic       latch_ev,
  input logic       arm_ev,
  input logic       commit_ev,
  input logic       clear_ev
);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[6] == 1'b0) && (reg_rdata[5] == 1'b0) && (reg_rdata[0] == 1'b0));

  a_r2_seq_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    acc_seq |-> !reg_sel);

  a_r4_latch_sets_wel: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev |=> reg_rdata[1] && $stable(reg_rdata[7:3]));

  a_r5_arm_sets_rwel: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ev |=> reg_rdata[2]);

  a_r6_commit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> !reg_rdata[2] && reg_rdata[1]);

  a_r7_clear_drops_latch: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ev |=> reg_rdata[2:1] == 2'b00);

  a_r8_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_rdata[7] && wp_pin) |=> $stable(reg_rdata));

  a_r9_permit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> reg_rdata[1] && !wp_pin && !blocked && acc_wr);

  a_r10_array_path_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !reg_sel) |=> $stable(reg_rdata));
endmodule

bind wpr_unit wpr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_seq(acc_seq),
  .wp_pin(wp_pin), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .arr_wr_ok(arr_wr_ok), .blocked(blocked), .reg_rdata(reg_rdata),
  .latch_ev(latch_ev), .arm_ev(arm_ev), .commit_ev(commit_ev),
  .clear_ev(clear_ev)
);

// File: tb/tb_wpr_unit.sv
`timescale 1ns/1ps
module tb_wpr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0, acc_seq = 1'b0, wp_pin = 1'b0;
  logic        reg_sel, reg_rd_en, arr_rd_en, arr_wr_ok;
  logic [7:0]  reg_rdata;

  int vec = 0, bad = 0;
  bit done = 0;

  // behavioural model state
  int m_wel = 0, m_rwel = 0, m_wpen = 0, m_bp = 0;

  always #2.5 clk = ~clk;

  wpr_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_seq(acc_seq), .wp_pin(wp_pin),
    .reg_sel(reg_sel), .reg_rd_en(reg_rd_en), .arr_rd_en(arr_rd_en),
    .arr_wr_ok(arr_wr_ok), .reg_rdata(reg_rdata)
  );

  function automatic int exp_reg();
    return m_wpen * 128 + m_bp * 8 + m_rwel * 4 + m_wel * 2;
  endfunction

  function automatic bit guarded(int a);
    if (m_bp == 0) return 0;
    if (m_bp == 1) return a >= 6144;
    if (m_bp == 2) return a >= 4096;
    return 1;
  endfunction

  task automatic cmp(string tag, string what, int act, int expv);
    vec++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // one access cycle: drive, compare all outputs, then advance the model
  task automatic step(string tag, int a, int d, bit wr, bit rd, bit sq, bit wp);
    bit sel;
    int c;
    @(negedge clk);
    acc_addr = 13'(a); acc_wdata = 8'(d); acc_wr = wr; acc_rd = rd;
    acc_seq = sq; wp_pin = wp;
    #1;
    sel = (a == 8191) && !sq;
    cmp(tag, "reg_rdata", int'(reg_rdata), exp_reg());
    cmp(tag, "reg_sel", int'(reg_sel), int'(sel));
    cmp(tag, "reg_rd_en", int'(reg_rd_en), int'(rd && sel));
    cmp(tag, "arr_rd_en", int'(arr_rd_en), int'(rd && !sel));
    cmp(tag, "arr_wr_ok", int'(arr_wr_ok),
        int'(wr && !sel && m_wel == 1 && !wp && !guarded(a)));
    @(posedge clk);
    if (wr && sel && !(m_wpen == 1 && wp)) begin
      c = (d >> 1) & 3;
      if (c == 1) begin
        if (m_rwel == 1) begin
          m_wpen = (d >> 7) & 1; m_bp = (d >> 3) & 3; m_rwel = 0;
        end else m_wel = 1;
      end else if (c == 3) begin
        if (m_wel == 1) m_rwel = 1;
      end else if (c == 0) begin
        m_wel = 0; m_rwel = 0;
      end
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic regw(string tag, int d, bit wp);
    step(tag, 8191, d, 1, 0, 0, wp);
    idle(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1");                              // reset value, no permit
    step("R1", 16'h0100, 8'h55, 1, 0, 0, 0);
    step("R2", 8191, 0, 0, 1, 0, 0);         // random read -> register
    step("R2", 8191, 0, 0, 1, 1, 0);         // sequential read -> array
    step("R2", 16'h0100, 0, 0, 1, 0, 0);
    regw("R5", 8'h06, 0);                    // arm without latch: no effect
    regw("R4", 8'h02, 0);                    // latch
    step("R9", 16'h0100, 8'hAA, 1, 0, 0, 0); // permitted
    step("R9", 16'h0100, 8'hAA, 1, 0, 0, 1); // pin blocks
    regw("R4", 8'h9A, 0);                    // latch again: BP/WPEN untouched
    regw("R5", 8'h06, 0);                    // arm
    regw("R6", 8'hFB, 0);                    // commit WPEN=1 BP=11, R3 bits drop
    step("R3", 8191, 0, 0, 1, 0, 0);
    step("R9", 0, 8'h11, 1, 0, 0, 0);        // whole array guarded
    regw("R8", 8'h00, 1);                    // locked by pin
    regw("R8", 8'h06, 1);
    regw("R7", 8'h04, 0);                    // bits 2:1 = 10 ignored
    regw("R7", 8'h00, 0);                    // clear latch
    step("R9", 16'h0100, 8'h22, 1, 0, 0, 0); // no latch -> refused
    regw("R11", 8'h02, 0);
    regw("R11", 8'h06, 0);
    regw("R6", 8'h0A, 0);                    // WPEN=0 BP=01
    step("R9", 16'h1800, 8'h33, 1, 0, 0, 0);
    step("R9", 16'h17FF, 8'h33, 1, 0, 0, 0);
    regw("R5", 8'h06, 0);
    regw("R6", 8'h12, 0);                    // BP=10
    step("R9", 16'h1000, 8'h44, 1, 0, 0, 0);
    step("R9", 16'h0FFF, 8'h44, 1, 0, 0, 0);
    regw("R5", 8'h06, 0);
    regw("R6", 8'h02, 0);                    // BP=00
    step("R10", 8191, 8'h00, 1, 0, 1, 0);    // sequential write at top
    idle("R10");
    step("R9", 16'h1FFE, 8'h44, 1, 0, 0, 0);
    regw("R8", 8'h00, 1);                    // WPEN=0: pin does not lock
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule